// File: doc/BRIEF.md
# Asynchronous Static RAM Bridge

This block lets a clocked system use an asynchronous 256K x 16 static RAM. It has byte-lane control. On the host side there is a request/ready handshake. A request carries an 18-bit word address, 16 bits of write data, two byte-enable bits and a read/write flag. Read data comes back with a one-cycle valid strobe. On the memory side the block drives the address, five active-low controls (chip select, write strobe, output enable, lower-byte and upper-byte strobes) and a 16-bit data bus. The bus is split into an output value, an input value and a drive enable.

Each memory access is a run of whole clock cycles. The length of every phase comes from the nanosecond limits of the memory, divided by the clock period and rounded up.
- A read holds chip select and output enable low long enough to cover both the address access time and the output-enable access time. The word is captured at the end of that window.
- A write pulls chip select and the write strobe low together, with the address already stable. It holds the pulse long enough for the address-valid, pulse-width and data-setup limits, then releases everything on one edge.
- Chip select goes high between any two accesses. A change between read and write therefore always comes with a chip-select toggle.
- After a read, the block waits for the memory's output turn-off time before it can drive the bus again.

Top module: `asram_bridge`

## Requirements
- R1: While reset is asserted, req_ready is 1, rsp_valid is 0, mem_dq_oe is 0 and all five memory controls are high.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 1 only while no memory access is in progress, and it stays 0 for the whole access and its recovery.
- R3: A read holds mem_ce_n and mem_oe_n low and mem_we_n high for RD_CYC = ceil(max(55, 30) / CLK_NS) cycles (14 at 4 ns). The word on mem_dq_in at the last edge of that window appears on rsp_data, with rsp_valid high for exactly the next cycle.
- R4: A write with at least one byte enable holds mem_ce_n and mem_we_n low and mem_oe_n high for WR_CYC = ceil(max(55, 30, 25) / CLK_NS) cycles (14 at 4 ns). mem_dq_oe is high and mem_dq_out holds the write data for exactly those cycles.
- R5: mem_addr changes only on the edge that takes a request. It never changes while mem_we_n is low.
- R6: req_be bit 0 enables the lower lane (data bits 7:0) and drives mem_lb_n low. Bit 1 enables the upper lane (bits 15:8) and drives mem_ub_n low. Both strobes are high whenever chip select is high. Reads use the same mapping.
- R7: A write request with req_be = 2'b00 is taken but starts no memory cycle. mem_we_n stays high, req_ready stays 1 and memory contents do not change.
- R8: mem_ce_n is high for at least one cycle between two accesses. While it stays low, mem_we_n, mem_oe_n and mem_addr do not change.
- R9: After a read, the block does not drive the bus for TURN_CYC = ceil(25 / CLK_NS) cycles (7 at 4 ns) after mem_oe_n rises. req_ready returns RD_CYC + TURN_CYC cycles after a read is taken, and WR_CYC cycles after a write is taken.
- R10: mem_oe_n and mem_we_n are never low together, and mem_dq_oe is high only while mem_oe_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 16 | Captured read word |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_in | input | 16 | Data returned from the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
The assertions check every cycle the relations between the pins:
- read enable and write strobe are exclusive, and the bus is never driven while the memory drives it;
- the address holds still under the write strobe;
- the control signals cannot change while chip select stays low;
- the lane strobes follow chip select;
- the response pulse lasts one cycle;
- the turn-off wait after a read is respected.

The bench's memory model times each read and each write pulse in nanoseconds and stores only the enabled lanes. Its reference model predicts every pin on every cycle. Only these scenarios can show that the phase lengths are correct, that the right word and lanes reach the host, and that an empty-enable write leaves memory unchanged.

// File: rtl/asb_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the asynchronous SRAM bridge.
// Assumes: phase limits are given in whole nanoseconds.
package asb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_TURN  = 2'd3
    } asb_state_e;

    // Larger of two limits.
    function automatic int unsigned lim_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Cycles covering a time limit, rounded up, never fewer than one.
    function automatic int unsigned cycles_for(input int unsigned ns, input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/asb_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that times one memory phase.
// Assumes: load and count never happen together; done is high when the count is zero.
module asb_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load the phase length, then count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/asb_seq.sv
`timescale 1ns/1ps
// Access sequencer: idle -> read -> turnaround -> idle, or idle -> write -> idle.
// Assumes: the phase timer counts cycles from the load value down to zero;
// a write with no byte enabled is taken but never leaves idle.
module asb_seq
    import asb_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int RD_CYC   = 14,
    parameter int WR_CYC   = 14,
    parameter int TURN_CYC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_be,
    input  logic             phase_done,
    output asb_state_e       state,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);

    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

    asb_state_e state_q, state_d;

    // Next-state and timer-load decode.
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        capture  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (!req_write) begin
                        state_d  = ST_READ;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end else if (|req_be) begin
                        state_d  = ST_WRITE;
                        tmr_load = 1'b1;
                        tmr_val  = WR_LOAD;
                    end
                end
            end
            ST_READ: begin
                if (phase_done) begin
                    capture  = 1'b1;
                    state_d  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = TURN_LOAD;
                end
            end
            ST_WRITE: begin
                if (phase_done) state_d = ST_IDLE;
            end
            ST_TURN: begin
                if (phase_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/asb_datapath.sv
`timescale 1ns/1ps
// Request holding registers, read capture and memory pin decode.
// Assumes: address, data and enables are latched only when a request is taken,
// so they stay still for the whole access.
module asb_datapath
    import asb_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  asb_state_e        state,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);

    localparam int LANES = 2;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic [LANES-1:0]  strb_n;
    logic              rd_act, wr_act, sel;

    // Hold the accepted request for the duration of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // Capture the read word and pulse the response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_data <= mem_dq_in;
        end
    end

    assign rd_act = (state == ST_READ);
    assign wr_act = (state == ST_WRITE);
    assign sel    = rd_act | wr_act;

    // One active-low strobe per byte lane, only while selected.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign strb_n[g] = ~(sel & be_q[g]);
    end

    assign req_ready  = (state == ST_IDLE);
    assign mem_addr   = addr_q;
    assign mem_ce_n   = ~sel;
    assign mem_oe_n   = ~rd_act;
    assign mem_we_n   = ~wr_act;
    assign mem_lb_n   = strb_n[0];
    assign mem_ub_n   = strb_n[1];
    assign mem_dq_out = wdata_q;
    assign mem_dq_oe  = wr_act;

endmodule

// File: rtl/asram_bridge.sv
`timescale 1ns/1ps
// Top level: synchronous host port to an asynchronous 16-bit static RAM.
// Assumes: every phase length is a whole number of CLK_NS cycles,
// derived from the memory's nanosecond limits by rounding up.
module asram_bridge
    import asb_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int CLK_NS    = 4,
    parameter int T_AA_NS   = 55,
    parameter int T_OE_NS   = 30,
    parameter int T_AW_NS   = 55,
    parameter int T_WP_NS   = 30,
    parameter int T_DW_NS   = 25,
    parameter int T_OHZ_NS  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int RD_CYC   = cycles_for(lim_max(T_AA_NS, T_OE_NS), CLK_NS);
    localparam int WR_CYC   = cycles_for(lim_max(lim_max(T_AW_NS, T_WP_NS), T_DW_NS), CLK_NS);
    localparam int TURN_CYC = cycles_for(T_OHZ_NS, CLK_NS);
    localparam int LONGEST  = lim_max(lim_max(RD_CYC, WR_CYC), TURN_CYC);
    localparam int CNT_W    = $clog2(LONGEST + 1);

    asb_state_e       state;
    logic             accept, capture, tmr_load, phase_done;
    logic [CNT_W-1:0] tmr_val;

    asb_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (phase_done)
    );

    asb_seq #(
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .WR_CYC   (WR_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_be     (req_be),
        .phase_done (phase_done),
        .state      (state),
        .accept     (accept),
        .capture    (capture),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val)
    );

    asb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .mem_dq_in  (mem_dq_in),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_lb_n   (mem_lb_n),
        .mem_ub_n   (mem_ub_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

endmodule

// File: rtl/asram_bridge_chk.sv
`timescale 1ns/1ps
// Protocol checker for the SRAM bridge pins, bound to the top level.
// Assumes: reset is synchronous and active low; TURN_CYC matches the top's turnaround.
module asram_bridge_chk #(
    parameter int ADDR_W   = 18,
    parameter int TURN_CYC = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic              mem_dq_oe
);

    localparam int HW = $clog2(TURN_CYC + 2);
    localparam logic [HW-1:0] SAT = HW'(TURN_CYC);

    logic [HW-1:0] oe_hi_cnt;

    // Cycles spent with output enable high, saturating at the turnaround length.
    always_ff @(posedge clk) begin
        if (!rst_n)              oe_hi_cnt <= SAT;
        else if (!mem_oe_n)      oe_hi_cnt <= '0;
        else if (oe_hi_cnt < SAT) oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end

    AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> mem_ce_n); // R2
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R3
    AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> mem_dq_oe); // R4
    AST_ADDR_STILL_UNDER_WE: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr)); // R5
    AST_STROBES_NEED_CE: assert property (@(posedge clk) disable iff (!rst_n) mem_ce_n |-> (mem_lb_n && mem_ub_n)); // R6
    AST_CE_LOW_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n) (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_we_n) && $stable(mem_oe_n) && $stable(mem_addr))); // R8
    AST_TURNAROUND_WAIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_dq_oe) |-> (oe_hi_cnt >= SAT)); // R9
    AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> mem_we_n); // R10
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> mem_oe_n); // R10

endmodule

bind asram_bridge asram_bridge_chk #(.ADDR_W(ADDR_W), .TURN_CYC(TURN_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_asram_bridge.sv
`timescale 1ns/1ps
// Bench: a timed behavioural memory on the pins, plus a cycle reference model compared every clock.
module tb_asram_bridge;

    localparam int P    = 4;
    localparam int RD   = (55 + P - 1) / P;
    localparam int WR   = (55 + P - 1) / P;
    localparam int TURN = (25 + P - 1) / P;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_data;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hBAD0;

    int n_checks = 0, n_fail = 0;
    bit finished = 0, run_chk = 0;
    int we_lows = 0;

    always #2 clk = ~clk;

    asram_bridge dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] init_val(input logic [17:0] a);
        return a[15:0] ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] lane_mask(input logic [15:0] w, input logic [1:0] be);
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    // ---------------- pin-level memory model ----------------
    logic [15:0] bus_mem [logic [17:0]];
    logic [15:0] ref_mem [logic [17:0]];

    function automatic logic [15:0] bus_word(input logic [17:0] a);
        return bus_mem.exists(a) ? bus_mem[a] : init_val(a);
    endfunction

    function automatic logic [15:0] ref_word(input logic [17:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
    endfunction

    initial begin
        real now, t_rd0, t_w0, t_d, t_oe_rise;
        logic reading, writing, w_ok, wlb, wub, prev_oe_n, prev_dq_oe;
        logic [17:0] rd_addr, waddr;
        logic [15:0] wdat, w;
        reading = 0; writing = 0; w_ok = 0; wlb = 0; wub = 0;
        prev_oe_n = 1; prev_dq_oe = 0; t_oe_rise = -1000.0;
        t_rd0 = 0.0; t_w0 = 0.0; t_d = 0.0; rd_addr = '0; waddr = '0; wdat = '0;
        #0.5;
        forever begin
            now = $realtime;
            if (rst_n) begin
                if (mem_oe_n && !prev_oe_n) t_oe_rise = now;
                if (mem_dq_oe && !prev_dq_oe)
                    chk(now - t_oe_rise >= 25.0, "R9 bus driven too soon after read", $rtoi(now - t_oe_rise), 25);
                // read: data appears only after the access time
                if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
                    if (!reading || mem_addr != rd_addr) begin
                        reading = 1; t_rd0 = now; rd_addr = mem_addr;
                    end
                    if (now - t_rd0 >= 55.0) begin
                        w = bus_word(mem_addr);
                        mem_dq_in = {mem_ub_n ? 8'h00 : w[15:8], mem_lb_n ? 8'h00 : w[7:0]};
                    end else begin
                        mem_dq_in = 16'hBAD0;
                    end
                end else begin
                    reading = 0;
                    mem_dq_in = 16'hBAD0;
                end
                // write: store enabled lanes when the pulse ends
                if (!mem_ce_n && !mem_we_n) begin
                    if (!writing) begin
                        writing = 1; t_w0 = now; t_d = now; wdat = mem_dq_out; waddr = mem_addr; w_ok = 1;
                    end
                    if (mem_dq_out !== wdat) begin t_d = now; wdat = mem_dq_out; end
                    if (!mem_dq_oe) w_ok = 0;
                    if (mem_addr != waddr) chk(0, "R5 address moved under write strobe", 32'(mem_addr), 32'(waddr));
                    wlb = !mem_lb_n; wub = !mem_ub_n;
                end else if (writing) begin
                    writing = 0;
                    chk(now - t_w0 >= 55.0, "R4 write pulse length ns", $rtoi(now - t_w0), 55);
                    chk(now - t_d >= 25.0, "R4 write data setup ns", $rtoi(now - t_d), 25);
                    chk(w_ok, "R4 data driven through pulse", 32'(w_ok), 1);
                    w = bus_word(waddr);
                    if (wlb) w[7:0] = wdat[7:0];
                    if (wub) w[15:8] = wdat[15:8];
                    bus_mem[waddr] = w;
                end
                prev_oe_n = mem_oe_n; prev_dq_oe = mem_dq_oe;
            end
            #1;
        end
    end

    // ---------------- cycle reference model ----------------
    int busy = 0, rcd = 0, wcd = 0;
    bit rv_exp = 0;
    logic [15:0] rd_exp = '0, cur_wdata = '0;
    logic [17:0] cur_addr = '0;
    logic [1:0]  cur_be = '0;

    always @(posedge clk) begin
        bit acc;
        logic [15:0] w;
        if (!rst_n) begin
            busy = 0; rcd = 0; wcd = 0; rv_exp = 0;
        end else begin
            acc = req_valid && (busy == 0);
            rv_exp = 0;
            if (busy > 0) busy--;
            if (rcd > 0) begin rcd--; if (rcd == 0) rv_exp = 1; end
            if (wcd > 0) wcd--;
            if (acc) begin
                cur_addr = req_addr; cur_be = req_be; cur_wdata = req_wdata;
                if (req_write) begin
                    if (req_be != 2'b00) begin
                        busy = WR; wcd = WR;
                        w = ref_word(req_addr);
                        if (req_be[0]) w[7:0] = req_wdata[7:0];
                        if (req_be[1]) w[15:8] = req_wdata[15:8];
                        ref_mem[req_addr] = w;
                    end
                end else begin
                    busy = RD + TURN; rcd = RD;
                    rd_exp = lane_mask(ref_word(req_addr), req_be);
                end
            end
        end
    end

    // Compare every pin against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            if (!mem_we_n) we_lows++;
            chk(req_ready == (busy == 0), "R2 req_ready", 32'(req_ready), 32'(busy == 0));
            chk(rsp_valid == rv_exp, "R3 rsp_valid", 32'(rsp_valid), 32'(rv_exp));
            if (rv_exp) chk(rsp_data == rd_exp, "R3 rsp_data", 32'(rsp_data), 32'(rd_exp));
            chk(mem_oe_n == !(rcd > 0), "R3 mem_oe_n", 32'(mem_oe_n), 32'(!(rcd > 0)));
            chk(mem_we_n == !(wcd > 0), "R4 mem_we_n", 32'(mem_we_n), 32'(!(wcd > 0)));
            chk(mem_dq_oe == (wcd > 0), "R4 mem_dq_oe", 32'(mem_dq_oe), 32'(wcd > 0));
            chk(mem_ce_n == !(rcd > 0 || wcd > 0), "R8 mem_ce_n", 32'(mem_ce_n), 32'(!(rcd > 0 || wcd > 0)));
            if (rcd > 0 || wcd > 0) begin
                chk(mem_addr == cur_addr, "R5 mem_addr", 32'(mem_addr), 32'(cur_addr));
                chk(mem_lb_n == !cur_be[0], "R6 mem_lb_n", 32'(mem_lb_n), 32'(!cur_be[0]));
                chk(mem_ub_n == !cur_be[1], "R6 mem_ub_n", 32'(mem_ub_n), 32'(!cur_be[1]));
            end else begin
                chk(mem_lb_n && mem_ub_n, "R6 strobes idle", {mem_ub_n, mem_lb_n}, 2'b11);
            end
            if (wcd > 0) chk(mem_dq_out == cur_wdata, "R4 mem_dq_out", 32'(mem_dq_out), 32'(cur_wdata));
        end
    end

    // ---------------- stimulus ----------------
    task automatic op(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
        req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(input logic [17:0] a, input logic [1:0] be, output logic [15:0] q);
        op(1'b0, a, 16'h0000, be);
        while (!rsp_valid) @(negedge clk);
        q = rsp_data;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * P);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [15:0] q;
        int w0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
        chk(mem_dq_oe == 1'b0, "R1 dq_oe in reset", 32'(mem_dq_oe), 0);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'h1F, "R1 controls high",
            32'({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}), 32'h1F);
        rst_n = 1'b1; run_chk = 1;
        @(negedge clk);

        op(1'b1, 18'h00010, 16'hA5C3, 2'b11);
        rd(18'h00010, 2'b11, q);
        chk(q == 16'hA5C3, "R3 read returns written word", 32'(q), 32'hA5C3);

        op(1'b1, 18'h00010, 16'h7E00, 2'b10);
        rd(18'h00010, 2'b11, q);
        chk(q == 16'h7EC3, "R6 upper lane write only", 32'(q), 32'h7EC3);

        op(1'b1, 18'h00010, 16'h0011, 2'b01);
        rd(18'h00010, 2'b11, q);
        chk(q == 16'h7E11, "R6 lower lane write only", 32'(q), 32'h7E11);

        w0 = we_lows;
        op(1'b1, 18'h00010, 16'hFFFF, 2'b00);
        chk(we_lows == w0, "R7 no write strobe for empty enables", 32'(we_lows - w0), 0);
        chk(req_ready == 1'b1, "R7 ready stays high", 32'(req_ready), 1);
        rd(18'h00010, 2'b11, q);
        chk(q == 16'h7E11, "R7 contents unchanged", 32'(q), 32'h7E11);

        rd(18'h00010, 2'b01, q);
        chk(q == 16'h0011, "R6 partial read lower lane", 32'(q), 32'h0011);

        rd(18'h3FFFF, 2'b11, q);
        chk(q == init_val(18'h3FFFF), "R3 untouched top word", 32'(q), 32'(init_val(18'h3FFFF)));

        // write directly followed by read (R8), read directly followed by write (R9)
        op(1'b1, 18'h00000, 16'h1357, 2'b11);
        rd(18'h00000, 2'b11, q);
        chk(q == 16'h1357, "R8 write then read switch", 32'(q), 32'h1357);
        op(1'b1, 18'h00020, 16'h2468, 2'b11);
        rd(18'h00020, 2'b11, q);
        chk(q == 16'h2468, "R9 read then write turnaround", 32'(q), 32'h2468);

        for (int i = 0; i < 8; i++)
            op(1'b1, 18'(i * 18'h04321 + 5), 16'(i * 16'h1111 ^ 16'hC0DE), 2'b11);
        for (int i = 0; i < 8; i++) begin
            rd(18'(i * 18'h04321 + 5), 2'b11, q);
            chk(q == 16'(i * 16'h1111 ^ 16'hC0DE), "R3 pattern readback", 32'(q), 32'(i * 16'h1111 ^ 16'hC0DE));
        end

        repeat (30) @(negedge clk);
        summary();
    end

endmodule